// File: doc/BRIEF.md
# PCIe Configuration Window Base Decoder

This block holds the 64-bit base register of a host bridge's memory-mapped PCIe configuration window and turns it into a ready-to-use decode. Firmware writes the register through a byte-addressed configuration write port, one dword at a time, with per-byte enables. The decoder takes three things from the stored value: an enable bit, a two-bit size selector and a base address. The selected size sets the address mask, so a smaller window gives a finer base alignment. The block outputs the decoded window, a hit flag for a probe address, and the lower bound of the 32-bit PCI memory hole that sits above the window.

The decode is refreshed by a two-state controller. `ST_IDLE` waits for a configuration write that touches either dword of the register. Transition `idle_to_update` fires on such a write. In `ST_UPDATE` the controller loads the decode from the register. It then takes `update_to_idle` when no further register write is present, or `update_hold` when one arrives in the same cycle. A size selector holding the reserved code leaves the decode as it was and latches an error flag.

Top module: `pcie_cfgwin_decoder`

## Requirements
- R1: After reset the register holds `RESET_BASE` (default 0xB000_0000). The outputs are then win_enable=0, win_base=0xB000_0000, win_length=0x1000_0000, hole_start=0xB000_0000, len_err=0 and win_hit=0.
- R2: A write to dword offset `CFG_OFFSET` (bytes 0-3 of the register) or `CFG_OFFSET`+4 (bytes 4-7) updates only the bytes whose enable bit is set. The new decode appears on the outputs after the second rising edge following the write cycle, and not before.
- R3: A write to any other dword offset, or a write with all byte enables low, leaves every decode output unchanged.
- R4: Register bits 2:1 select the window size: 0 gives 256 MiB, 1 gives 128 MiB, 2 gives 64 MiB. The window base is the register AND the mask for the size: bits PA_W-1..28 for 256 MiB, with bit 27 added for 128 MiB, and bits 27..26 added for 64 MiB. Register bits at or above PA_W are ignored.
- R5: Register bit 0 drives win_enable.
- R6: While enabled, hole_start equals win_base + win_length. While disabled, it equals the default base 0xB000_0000.
- R7: Size code 3 is reserved. Decoding it leaves win_enable, win_base, win_length and hole_start unchanged and sets len_err, which stays set until reset.
- R8: win_hit is high exactly when win_enable is set and win_base <= probe_addr <= win_base + win_length - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration byte address of the dword (bits 1:0 ignored) |
| cfg_wr_be | input | 4 | Byte enables within the dword |
| cfg_wr_data | input | 32 | Write data |
| probe_addr | input | PA_W | Address tested against the window |
| win_enable | output | 1 | Window enabled |
| win_base | output | PA_W | Decoded window base |
| win_length | output | PA_W | Window size in bytes |
| hole_start | output | PA_W | Lower bound of the 32-bit PCI memory hole |
| win_hit | output | 1 | probe_addr lies inside the enabled window |
| len_err | output | 1 | Sticky flag: the reserved size code was decoded |

## Verification
The size decode is tried with register values that place set bits at positions 27 and 26. Those bits are kept or cleared depending on the size, which separates a correct mask from a fixed or swapped one. Other vectors place data above bit PA_W-1 and in the unused middle field, to show those bits are ignored. Probes just inside and just outside each window separate a correct upper bound from an off-by-one. Partial and misdirected writes show that only the enabled bytes of the two target dwords reach the decode. The reserved code followed by a valid code shows that the error flag is sticky and does not block later decodes.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    // Size selector codes (register bits 2:1)
    typedef enum logic [1:0] {
        SEL_256M = 2'd0,
        SEL_128M = 2'd1,
        SEL_64M  = 2'd2,
        SEL_RSVD = 2'd3
    } win_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_UPDATE = 1'b1
    } upd_state_e;

    localparam int EN_BIT  = 0;
    localparam int SEL_LSB = 1;

endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg #(
    parameter int                  DW        = 32,
    parameter int                  NDW       = 2,
    parameter logic [7:0]          OFFSET    = 8'h60,
    parameter logic [DW*NDW-1:0]   RESET_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [DW/8-1:0]      wr_be,
    input  logic [DW-1:0]        wr_data,
    output logic [DW*NDW-1:0]    reg_q,
    output logic                 wr_hit
);
    localparam int BPD = DW / 8;
    localparam int LSB = $clog2(BPD);
    localparam int IW  = 8 - LSB;

    logic [NDW-1:0] dw_sel;

    for (genvar d = 0; d < NDW; d++) begin : g_sel
        assign dw_sel[d] = wr_en && (wr_addr[7:LSB] == (OFFSET[7:LSB] + IW'(d)));
    end

    logic unused_lsb;
    assign unused_lsb = ^wr_addr[LSB-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RESET_VAL;
        end else begin
            for (int d = 0; d < NDW; d++) begin
                for (int b = 0; b < BPD; b++) begin
                    if (dw_sel[d] && wr_be[b])
                        reg_q[(d*BPD + b)*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    assign wr_hit = (|dw_sel) && (|wr_be);

endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
    import cfgwin_pkg::*;
#(
    parameter int          PA_W         = 40,
    parameter int          MAX_LEN_LOG2 = 28,
    parameter logic [63:0] RESET_BASE   = 64'h0000_0000_B000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_req,
    input  logic [PA_W-1:0] reg_q,
    output logic            win_enable,
    output logic [PA_W-1:0] win_base,
    output logic [PA_W-1:0] win_length,
    output logic [PA_W-1:0] hole_start,
    output logic            len_err
);
    localparam logic [PA_W-1:0] ONE      = PA_W'(1);
    localparam logic [PA_W-1:0] RST_LEN  = ONE << (MAX_LEN_LOG2 - int'(RESET_BASE[SEL_LSB +: 2]));
    localparam logic [PA_W-1:0] RST_ADDR = RESET_BASE[PA_W-1:0] & ~(RST_LEN - ONE);
    localparam logic            RST_EN   = RESET_BASE[EN_BIT];
    localparam logic [PA_W-1:0] RST_HOLE = RST_EN ? (RST_ADDR + RST_LEN) : RST_ADDR;

    upd_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: idle_to_update, update_hold, update_to_idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (upd_req) state_d = ST_UPDATE;
            ST_UPDATE: state_d = upd_req ? ST_UPDATE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Candidate decode from the stored register
    win_sel_e        sel_w;
    logic            en_w;
    logic [PA_W-1:0] len_w;
    logic [PA_W-1:0] base_w;

    assign sel_w = win_sel_e'(reg_q[SEL_LSB +: 2]);
    assign en_w  = reg_q[EN_BIT];

    always_comb begin
        unique case (sel_w)
            SEL_256M: len_w = ONE << MAX_LEN_LOG2;
            SEL_128M: len_w = ONE << (MAX_LEN_LOG2 - 1);
            SEL_64M:  len_w = ONE << (MAX_LEN_LOG2 - 2);
            default:  len_w = win_length;
        endcase
    end

    assign base_w = reg_q & ~(len_w - ONE);

    logic unused_mid;
    assign unused_mid = ^reg_q[MAX_LEN_LOG2-3:SEL_LSB+2];

    // Output registers, loaded in ST_UPDATE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_enable <= RST_EN;
            win_base   <= RST_ADDR;
            win_length <= RST_LEN;
            hole_start <= RST_HOLE;
            len_err    <= 1'b0;
        end else if (state_q == ST_UPDATE) begin
            if (sel_w == SEL_RSVD) begin
                len_err <= 1'b1;
            end else begin
                win_enable <= en_w;
                win_base   <= base_w;
                win_length <= len_w;
                hole_start <= en_w ? (base_w + len_w) : RST_ADDR;
            end
        end
    end

endmodule

// File: rtl/cfgwin_hit.sv
module cfgwin_hit #(
    parameter int PA_W = 40
) (
    input  logic            en,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] len,
    input  logic [PA_W-1:0] probe,
    output logic            hit
);
    logic [PA_W:0] end_x;

    assign end_x = {1'b0, base} + {1'b0, len};
    assign hit   = en && (probe >= base) && ({1'b0, probe} < end_x);

endmodule

// File: rtl/pcie_cfgwin_decoder.sv
module pcie_cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int          PA_W         = 40,
    parameter int          MAX_LEN_LOG2 = 28,
    parameter logic [7:0]  CFG_OFFSET   = 8'h60,
    parameter logic [63:0] RESET_BASE   = 64'h0000_0000_B000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr_en,
    input  logic [7:0]      cfg_wr_addr,
    input  logic [3:0]      cfg_wr_be,
    input  logic [31:0]     cfg_wr_data,
    input  logic [PA_W-1:0] probe_addr,
    output logic            win_enable,
    output logic [PA_W-1:0] win_base,
    output logic [PA_W-1:0] win_length,
    output logic [PA_W-1:0] hole_start,
    output logic            win_hit,
    output logic            len_err
);
    localparam int DW    = 32;
    localparam int NDW   = 2;
    localparam int REG_W = DW * NDW;

    logic [REG_W-1:0] reg_q;
    logic             wr_hit;

    cfgwin_reg #(
        .DW(DW), .NDW(NDW), .OFFSET(CFG_OFFSET), .RESET_VAL(RESET_BASE)
    ) reg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_be(cfg_wr_be), .wr_data(cfg_wr_data),
        .reg_q(reg_q), .wr_hit(wr_hit)
    );

    if (PA_W < REG_W) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^reg_q[REG_W-1:PA_W];
    end

    cfgwin_ctrl #(
        .PA_W(PA_W), .MAX_LEN_LOG2(MAX_LEN_LOG2), .RESET_BASE(RESET_BASE)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .upd_req(wr_hit), .reg_q(reg_q[PA_W-1:0]),
        .win_enable(win_enable), .win_base(win_base), .win_length(win_length),
        .hole_start(hole_start), .len_err(len_err)
    );

    cfgwin_hit #(
        .PA_W(PA_W)
    ) hit_i (
        .en(win_enable), .base(win_base), .len(win_length), .probe(probe_addr), .hit(win_hit)
    );

endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
    parameter int          PA_W         = 40,
    parameter int          MAX_LEN_LOG2 = 28,
    parameter logic [7:0]  CFG_OFFSET   = 8'h60,
    parameter logic [63:0] RESET_BASE   = 64'h0000_0000_B000_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr_en,
    input logic [7:0]      cfg_wr_addr,
    input logic [3:0]      cfg_wr_be,
    input logic [PA_W-1:0] probe_addr,
    input logic            win_enable,
    input logic [PA_W-1:0] win_base,
    input logic [PA_W-1:0] win_length,
    input logic [PA_W-1:0] hole_start,
    input logic            win_hit,
    input logic            len_err
);
    localparam logic [PA_W-1:0] ONE      = PA_W'(1);
    localparam logic [PA_W-1:0] DEF_LEN  = ONE << (MAX_LEN_LOG2 - int'(RESET_BASE[2:1]));
    localparam logic [PA_W-1:0] FALLBACK = RESET_BASE[PA_W-1:0] & ~(DEF_LEN - ONE);

    logic ovl;
    assign ovl = cfg_wr_en && (|cfg_wr_be) &&
                 ((cfg_wr_addr[7:2] == CFG_OFFSET[7:2]) ||
                  (cfg_wr_addr[7:2] == CFG_OFFSET[7:2] + 6'd1));

    // R3
    decode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ovl) && !$past(ovl, 2)) |->
        ($stable(win_base) && $stable(win_enable) && $stable(win_length) && $stable(hole_start)));

    // R6
    hole_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_enable |-> (hole_start == FALLBACK));

    // R6
    hole_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_enable |-> (hole_start == win_base + win_length));

    // R4
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_base & (win_length - ONE)) == '0) && ($countones(win_length) == 1));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

    // R8
    hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (win_enable && (probe_addr >= win_base) && ((probe_addr - win_base) < win_length)));

endmodule

bind pcie_cfgwin_decoder cfgwin_checker #(
    .PA_W(PA_W), .MAX_LEN_LOG2(MAX_LEN_LOG2), .CFG_OFFSET(CFG_OFFSET), .RESET_BASE(RESET_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_be(cfg_wr_be), .probe_addr(probe_addr), .win_enable(win_enable),
    .win_base(win_base), .win_length(win_length), .hole_start(hole_start),
    .win_hit(win_hit), .len_err(len_err)
);

// File: tb/pcie_cfgwin_decoder_tb_top.sv
`timescale 1ns/1ps
module pcie_cfgwin_decoder_tb_top;
    localparam int PA_W = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_addr = '0;
    logic [3:0]      wr_be = '0;
    logic [31:0]     wr_data = '0;
    logic [PA_W-1:0] probe = '0;
    logic            win_enable, win_hit, len_err;
    logic [PA_W-1:0] win_base, win_length, hole_start;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcie_cfgwin_decoder #(.PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_addr(wr_addr),
        .cfg_wr_be(wr_be), .cfg_wr_data(wr_data), .probe_addr(probe),
        .win_enable(win_enable), .win_base(win_base), .win_length(win_length),
        .hole_start(hole_start), .win_hit(win_hit), .len_err(len_err)
    );

    typedef struct packed {
        logic [31:0]     lo;
        logic [31:0]     hi;
        logic [PA_W-1:0] prb;
        logic            en;
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] len;
        logic [PA_W-1:0] hole;
        logic            hit;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'hE000_0001, 32'h0, 40'h00_EFFF_FFFF, 1'b1, 40'h00_E000_0000, 40'h00_1000_0000, 40'h00_F000_0000, 1'b1},
        '{32'hE800_0003, 32'h0, 40'h00_F000_0000, 1'b1, 40'h00_E800_0000, 40'h00_0800_0000, 40'h00_F000_0000, 1'b0},
        '{32'hEC00_0005, 32'h0, 40'h00_EC00_0000, 1'b1, 40'h00_EC00_0000, 40'h00_0400_0000, 40'h00_F000_0000, 1'b1},
        '{32'hEC00_0001, 32'h0, 40'h00_EC00_0000, 1'b1, 40'h00_E000_0000, 40'h00_1000_0000, 40'h00_F000_0000, 1'b1},
        '{32'hEC00_0003, 32'h0, 40'h00_E7FF_FFFF, 1'b1, 40'h00_E800_0000, 40'h00_0800_0000, 40'h00_F000_0000, 1'b0},
        '{32'hC000_0000, 32'h0, 40'h00_C000_0000, 1'b0, 40'h00_C000_0000, 40'h00_1000_0000, 40'h00_B000_0000, 1'b0},
        '{32'h4000_0005, 32'h12, 40'h12_43FF_FFFF, 1'b1, 40'h12_4000_0000, 40'h00_0400_0000, 40'h12_4400_0000, 1'b1},
        '{32'h0000_0001, 32'hFFFF_FF01, 40'h01_0000_0000, 1'b1, 40'h01_0000_0000, 40'h00_1000_0000, 40'h01_1000_0000, 1'b1},
        '{32'h0FFF_FFF1, 32'h0, 40'h00_0000_0000, 1'b1, 40'h00_0000_0000, 40'h00_1000_0000, 40'h00_1000_0000, 1'b1}
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_dec(input string req, input logic en, input logic [PA_W-1:0] base,
                             input logic [PA_W-1:0] len, input logic [PA_W-1:0] hole);
        check(req, "win_enable", 64'(win_enable), 64'(en));
        check(req, "win_base",   64'(win_base),   64'(base));
        check(req, "win_length", 64'(win_length), 64'(len));
        check(req, "hole_start", 64'(hole_start), 64'(hole));
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic settle;
        repeat (2) @(negedge clk);
    endtask

    task automatic probe_chk(input string req, input logic [PA_W-1:0] a, input logic exp);
        probe = a;
        #1;
        check(req, "win_hit", 64'(win_hit), 64'(exp));
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        probe = 40'h00_B000_0000;
        #1;
        check_dec("R1", 1'b0, 40'h00_B000_0000, 40'h00_1000_0000, 40'h00_B000_0000);
        check("R1", "len_err", 64'(len_err), 64'd0);
        check("R1", "win_hit", 64'(win_hit), 64'd0);

        // R2 latency: old decode after first edge, new after the second
        cfg_write(8'h60, 4'hF, 32'hB000_0001);
        check("R2", "win_enable early", 64'(win_enable), 64'd0);
        @(negedge clk);
        check("R2", "win_enable late", 64'(win_enable), 64'd1);

        // Vector table: R4 R5 R6 R8
        for (int i = 0; i < 9; i++) begin
            cfg_write(8'h64, 4'hF, VECS[i].hi);
            cfg_write(8'h60, 4'hF, VECS[i].lo);
            settle();
            check_dec("R4/R5/R6", VECS[i].en, VECS[i].base, VECS[i].len, VECS[i].hole);
            probe_chk("R8", VECS[i].prb, VECS[i].hit);
        end

        // R7 reserved size code keeps decode, flags error
        cfg_write(8'h60, 4'hF, 32'h2000_0007);
        settle();
        check_dec("R7", 1'b1, 40'h0, 40'h00_1000_0000, 40'h00_1000_0000);
        check("R7", "len_err set", 64'(len_err), 64'd1);
        cfg_write(8'h60, 4'hF, 32'h2000_0001);
        settle();
        check_dec("R7", 1'b1, 40'h00_2000_0000, 40'h00_1000_0000, 40'h00_3000_0000);
        check("R7", "len_err sticky", 64'(len_err), 64'd1);

        // R2 partial byte writes
        cfg_write(8'h60, 4'b1000, 32'h30FF_FFFF);
        settle();
        check_dec("R2", 1'b1, 40'h00_3000_0000, 40'h00_1000_0000, 40'h00_4000_0000);
        cfg_write(8'h60, 4'b0001, 32'hFFFF_FF05);
        settle();
        check_dec("R2", 1'b1, 40'h00_3000_0000, 40'h00_0400_0000, 40'h00_3400_0000);
        cfg_write(8'h64, 4'b0001, 32'hAAAA_AA03);
        settle();
        check_dec("R2", 1'b1, 40'h03_3000_0000, 40'h00_0400_0000, 40'h03_3400_0000);

        // R3 writes elsewhere or without byte enables
        cfg_write(8'h68, 4'hF, 32'h0);
        cfg_write(8'h5C, 4'hF, 32'hFFFF_FFFF);
        cfg_write(8'h60, 4'h0, 32'h0);
        settle();
        check_dec("R3", 1'b1, 40'h03_3000_0000, 40'h00_0400_0000, 40'h03_3400_0000);
        check("R3", "len_err", 64'(len_err), 64'd1);

        // R8 window edges
        probe_chk("R8", 40'h03_2FFF_FFFF, 1'b0);
        probe_chk("R8", 40'h03_3000_0000, 1'b1);
        probe_chk("R8", 40'h03_33FF_FFFF, 1'b1);
        probe_chk("R8", 40'h03_3400_0000, 1'b0);

        // R5 R6 disable
        cfg_write(8'h60, 4'b0001, 32'h0000_0004);
        settle();
        check_dec("R5/R6", 1'b0, 40'h03_3000_0000, 40'h00_0400_0000, 40'h00_B000_0000);
        probe_chk("R8", 40'h03_3000_0000, 1'b0);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_dec("R1", 1'b0, 40'h00_B000_0000, 40'h00_1000_0000, 40'h00_B000_0000);
        check("R1", "len_err cleared", 64'(len_err), 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule